// File: doc/BRIEF.md
# ADC Power and Interference Monitor

This block watches one digitized real input stream of signed 8-bit samples. The samples arrive four per processing clock. Each clock, it squares the four samples and adds the squares together. It keeps two sums of these values. The first is a wide total over the whole interval between two sync pulses, which is nominally one second. The second is a short window whose length is a programmable power of two in samples. When a window is complete, its sum is compared once against a programmable threshold, and a saturating counter records how many windows exceeded it.

On every sync pulse the block does two things in the same cycle. It copies the interval total, the exceedance count and an event flag into snapshot registers, and it restarts its accumulators. The samples presented in the sync cycle belong to the new interval. Host software reads the snapshots through a small combinational read port. The monitor has no mode input and runs continuously.

A two-state controller sequences the block:
- `ST_WAIT_SYNC` is the state after reset. Nothing accumulates in it.
- The transition `T_FIRST_SYNC` is taken on the first sync pulse and leads to `ST_ACCUM`.
- `ST_ACCUM` keeps the block accumulating. Every later sync pulse is handled as `T_RESYNC`, which is a self-loop that snapshots the results and restarts the sums.

Top module: `adc_power_monitor`

## Requirements
- R1: After reset, all four readable registers return zero.
- R2: A cycle's power is the sum of the squares of the four signed 8-bit lanes of `samples`, with lane k in bits [8k+7:8k]. For example, four lanes of 0x80 give 65536, and four lanes of 0x7F give 64516.
- R3: On a sync pulse, the interval power snapshot takes the sum of the cycle powers from the previous sync cycle (inclusive) up to this sync cycle (exclusive). The snapshot can be read from the cycle after the sync edge and holds until the next sync.
- R4: Before the first sync pulse, nothing accumulates. The first sync pulse therefore latches zero power and a zero count.
- R5: A window lasts 2^L samples, which is 2^(L-2) clocks. L is `win_log` clamped to the range 6 to 12. L is sampled when the window starts, so a change made mid-window takes effect from the next window.
- R6: Each completed window is compared exactly once. It counts as an exceedance when its sum is strictly greater than `threshold`.
- R7: A sync pulse discards the partial window and starts a new window with that cycle's samples. A window whose last cycle coincides with the sync pulse is not counted.
- R8: The exceedance counter stops at 2^CNT_W-1 and does not wrap.
- R9: The event flag snapshot is 1 exactly when the latched exceedance count is nonzero.
- R10: Read map, selected by `rd_addr`:
  - 0: interval power bits [31:0]
  - 1: interval power bits [47:32], zero-extended
  - 2: exceedance count, zero-extended
  - 3: event flag in bit 0

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_pulse | input | 1 | One-cycle interval boundary strobe |
| samples | input | LANES*SW (32) | Four signed samples for this clock, lane 0 in the low byte |
| win_log | input | LOGW (4) | Requested window length as log2 of samples |
| threshold | input | THR_W (32) | Window power limit |
| rd_addr | input | 2 | Register select |
| rd_data | output | RD_W (32) | Selected snapshot register |

## Verification
Two functions can fall in the same cycle: the sync pulse, and the last clock of a short window. The bench provokes this by starting an interval with a sync pulse and using a threshold of zero. It then issues the next sync after 14 further clocks and, separately, after 15 further clocks. Under R7 the count must read 0 in the first case and 1 in the second. A mid-window change of `win_log` is judged the same way by the number of windows counted in a fixed 48-clock interval.

// File: rtl/amon_pkg.sv
package amon_pkg;

    typedef enum logic [0:0] {
        ST_WAIT_SYNC = 1'b0,
        ST_ACCUM     = 1'b1
    } amon_state_e;

    localparam int RD_ADDR_W = 2;

    localparam logic [RD_ADDR_W-1:0] RA_POW_LO = 2'd0;
    localparam logic [RD_ADDR_W-1:0] RA_POW_HI = 2'd1;
    localparam logic [RD_ADDR_W-1:0] RA_COUNT  = 2'd2;
    localparam logic [RD_ADDR_W-1:0] RA_FLAG   = 2'd3;

endpackage

// File: rtl/amon_lane_power.sv
module amon_lane_power #(
    parameter int LANES = 4,
    parameter int SW    = 8,
    parameter int CYC_W = 17
) (
    input  logic [LANES*SW-1:0] samples,
    output logic [CYC_W-1:0]    cyc_pow
);

    logic [CYC_W-1:0] sq [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic signed [SW-1:0]   s;
        logic signed [2*SW-1:0] p;

        assign s     = samples[g*SW +: SW];
        assign p     = s * s;
        assign sq[g] = CYC_W'($unsigned(p));
    end

    // Adds the squared lanes of this clock (R2).
    always_comb begin
        cyc_pow = '0;
        for (int i = 0; i < LANES; i++) begin
            cyc_pow = cyc_pow + sq[i];
        end
    end

endmodule

// File: rtl/amon_window.sv
module amon_window #(
    parameter int LOGW     = 4,
    parameter int LOG_MIN  = 6,
    parameter int LOG_MAX  = 12,
    parameter int LANE_LOG = 2,
    parameter int CYC_W    = 17,
    parameter int THR_W    = 32,
    parameter int WSUM_W   = LOG_MAX + CYC_W,
    parameter int WCNT_W   = LOG_MAX - LANE_LOG + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [LOGW-1:0]  win_log,
    input  logic [THR_W-1:0] threshold,
    input  logic [CYC_W-1:0] cyc_pow,
    output logic             over_pulse
);

    localparam int CMP_W = (WSUM_W > THR_W) ? WSUM_W : THR_W;

    logic [LOGW-1:0]   req_len;
    logic [LOGW-1:0]   len_q;
    logic [WCNT_W-1:0] wcnt_q;
    logic [WSUM_W-1:0] wsum_q;
    logic [WSUM_W-1:0] sum_next;
    logic [WCNT_W-1:0] last_idx;
    logic              win_done;

    // Clamp of the requested length (R5).
    always_comb begin
        if (win_log < LOGW'(LOG_MIN)) begin
            req_len = LOGW'(LOG_MIN);
        end else if (win_log > LOGW'(LOG_MAX)) begin
            req_len = LOGW'(LOG_MAX);
        end else begin
            req_len = win_log;
        end
    end

    assign sum_next   = wsum_q + WSUM_W'(cyc_pow);
    assign last_idx   = (WCNT_W'(1) << (len_q - LOGW'(LANE_LOG))) - WCNT_W'(1);
    assign win_done   = run && !restart && (wcnt_q == last_idx);
    assign over_pulse = win_done && (CMP_W'(sum_next) > CMP_W'(threshold));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wsum_q <= '0;
            wcnt_q <= '0;
            len_q  <= LOGW'(LOG_MIN);
        end else if (restart) begin
            wsum_q <= WSUM_W'(cyc_pow);
            wcnt_q <= WCNT_W'(1);
            len_q  <= req_len;
        end else if (!run) begin
            wsum_q <= '0;
            wcnt_q <= '0;
            len_q  <= req_len;
        end else if (win_done) begin
            wsum_q <= '0;
            wcnt_q <= '0;
            len_q  <= req_len;
        end else begin
            wsum_q <= sum_next;
            wcnt_q <= wcnt_q + WCNT_W'(1);
        end
    end

    a_r5_len_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (len_q >= LOGW'(LOG_MIN)) && (len_q <= LOGW'(LOG_MAX)));

    a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        wcnt_q <= last_idx);

    a_r7_no_compare_at_sync: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> !over_pulse);

    a_r6_window_closes: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |=> (wcnt_q == '0) && (wsum_q == '0));

endmodule

// File: rtl/amon_interval.sv
module amon_interval #(
    parameter int ACC_W = 48,
    parameter int CYC_W = 17,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic             over_pulse,
    input  logic [CYC_W-1:0] cyc_pow,
    output logic [ACC_W-1:0] snap_pow,
    output logic [CNT_W-1:0] snap_cnt,
    output logic             snap_flag
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [ACC_W-1:0] acc_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q     <= '0;
            cnt_q     <= '0;
            snap_pow  <= '0;
            snap_cnt  <= '0;
            snap_flag <= 1'b0;
        end else if (restart) begin
            snap_pow  <= acc_q;
            snap_cnt  <= cnt_q;
            snap_flag <= (cnt_q != '0);
            acc_q     <= ACC_W'(cyc_pow);
            cnt_q     <= '0;
        end else if (run) begin
            acc_q <= acc_q + ACC_W'(cyc_pow);
            if (over_pulse && (cnt_q != CNT_MAX)) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    a_r8_count_holds_at_max: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !restart) |=> (cnt_q == CNT_MAX));

    a_r9_flag_tracks_count: assert property (@(posedge clk) disable iff (!rst_n)
        snap_flag == (snap_cnt != '0));

    a_r3_snapshot_held: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> $stable(snap_pow) && $stable(snap_cnt));

    a_r4_idle_no_accum: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (acc_q == '0) && (cnt_q == '0));

endmodule

// File: rtl/adc_power_monitor.sv
module adc_power_monitor
    import amon_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int SW      = 8,
    parameter int LOGW    = 4,
    parameter int LOG_MIN = 6,
    parameter int LOG_MAX = 12,
    parameter int THR_W   = 32,
    parameter int ACC_W   = 48,
    parameter int CNT_W   = 16,
    parameter int RD_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sync_pulse,
    input  logic [LANES*SW-1:0]  samples,
    input  logic [LOGW-1:0]      win_log,
    input  logic [THR_W-1:0]     threshold,
    input  logic [RD_ADDR_W-1:0] rd_addr,
    output logic [RD_W-1:0]      rd_data
);

    localparam int LANE_LOG = $clog2(LANES);
    localparam int CYC_W    = 2*SW - 1 + LANE_LOG;

    amon_state_e state_q;
    amon_state_e state_d;
    logic        run;

    logic [CYC_W-1:0]  cyc_pow;
    logic              over_pulse;
    logic [ACC_W-1:0]  snap_pow;
    logic [CNT_W-1:0]  snap_cnt;
    logic              snap_flag;
    logic [2*RD_W-1:0] pow_ext;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT_SYNC;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: T_FIRST_SYNC leaves the wait state, T_RESYNC loops in ST_ACCUM.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_SYNC: if (sync_pulse) state_d = ST_ACCUM;
            ST_ACCUM:     state_d = ST_ACCUM;
            default:      state_d = ST_WAIT_SYNC;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_WAIT_SYNC: run = 1'b0;
            ST_ACCUM:     run = 1'b1;
            default:      run = 1'b0;
        endcase
    end

    amon_lane_power #(
        .LANES (LANES),
        .SW    (SW),
        .CYC_W (CYC_W)
    ) u_lanes (
        .samples (samples),
        .cyc_pow (cyc_pow)
    );

    amon_window #(
        .LOGW     (LOGW),
        .LOG_MIN  (LOG_MIN),
        .LOG_MAX  (LOG_MAX),
        .LANE_LOG (LANE_LOG),
        .CYC_W    (CYC_W),
        .THR_W    (THR_W)
    ) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .restart    (sync_pulse),
        .win_log    (win_log),
        .threshold  (threshold),
        .cyc_pow    (cyc_pow),
        .over_pulse (over_pulse)
    );

    amon_interval #(
        .ACC_W (ACC_W),
        .CYC_W (CYC_W),
        .CNT_W (CNT_W)
    ) u_interval (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .restart    (sync_pulse),
        .over_pulse (over_pulse),
        .cyc_pow    (cyc_pow),
        .snap_pow   (snap_pow),
        .snap_cnt   (snap_cnt),
        .snap_flag  (snap_flag)
    );

    assign pow_ext = (2*RD_W)'(snap_pow);

    // Read map (R10).
    always_comb begin
        unique case (rd_addr)
            RA_POW_LO: rd_data = pow_ext[RD_W-1:0];
            RA_POW_HI: rd_data = pow_ext[2*RD_W-1:RD_W];
            RA_COUNT:  rd_data = RD_W'(snap_cnt);
            RA_FLAG:   rd_data = RD_W'(snap_flag);
            default:   rd_data = '0;
        endcase
    end

    a_r4_leave_wait_only_on_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_SYNC && !sync_pulse) |=> (state_q == ST_WAIT_SYNC));

    a_r10_flag_word_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == RA_FLAG) |-> (rd_data[RD_W-1:1] == '0));

endmodule

// File: tb/adc_power_monitor_bench.sv
`timescale 1ns/1ps
module adc_power_monitor_bench;

    localparam int CNT_W   = 6;
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_pulse = 1'b0;
    logic [31:0] samples = '0;
    logic [3:0]  win_log = 4'd6;
    logic [31:0] threshold = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;

    bit      m_started = 0;
    longint  m_acc = 0;
    longint  m_wsum = 0;
    int      m_wcnt = 0;
    int      m_wlen = 6;
    int      m_cnt = 0;
    longint  e_pow = 0;
    int      e_cnt = 0;
    int      e_flag = 0;
    logic [31:0] rng = 32'h1234_5678;

    always #4 clk = ~clk;

    adc_power_monitor #(.CNT_W(CNT_W)) u_adc_power_monitor (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_pulse (sync_pulse),
        .samples    (samples),
        .win_log    (win_log),
        .threshold  (threshold),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data)
    );

    function automatic int clamp_len(input int v);
        if (v < 6) return 6;
        if (v > 12) return 12;
        return v;
    endfunction

    function automatic longint lane_pow(input logic [31:0] s);
        longint t = 0;
        for (int k = 0; k < 4; k++) begin
            int v = int'($signed(s[8*k +: 8]));
            t += longint'(v * v);
        end
        return t;
    endfunction

    function automatic logic [31:0] next_rng(input logic [31:0] x);
        logic [31:0] y = x;
        y = y ^ (y << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    task automatic check(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // One clock of stimulus with the reference model advanced.
    task automatic step(input logic [31:0] s, input bit sy);
        longint cp;
        @(negedge clk);
        samples    = s;
        sync_pulse = sy;
        @(posedge clk);
        cp = lane_pow(s);
        if (sy) begin
            e_pow  = m_acc;
            e_cnt  = m_cnt;
            e_flag = (m_cnt != 0);
            m_acc  = cp;
            m_cnt  = 0;
            m_wsum = cp;
            m_wcnt = 1;
            m_wlen = clamp_len(int'(win_log));
            m_started = 1;
        end else if (!m_started) begin
            m_wlen = clamp_len(int'(win_log));
        end else begin
            m_acc  += cp;
            m_wsum += cp;
            m_wcnt++;
            if (m_wcnt == (1 << (m_wlen - 2))) begin
                if (m_wsum > longint'(threshold) && m_cnt < CNT_MAX) m_cnt++;
                m_wsum = 0;
                m_wcnt = 0;
                m_wlen = clamp_len(int'(win_log));
            end
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic check_regs(input longint pow, input int cnt, input int flg, input string tag);
        logic [31:0] d;
        #1;
        rd(2'd0, d);
        check(d == pow[31:0], {tag, " R10 R3 power low"}, longint'(d), longint'(pow[31:0]));
        rd(2'd1, d);
        check(d == {16'd0, pow[47:32]}, {tag, " R10 R3 power high"}, longint'(d), longint'(pow[47:32]));
        rd(2'd2, d);
        check(d == 32'(cnt), {tag, " R6 count"}, longint'(d), longint'(cnt));
        rd(2'd3, d);
        check(d == 32'(flg), {tag, " R9 flag"}, longint'(d), longint'(flg));
    endtask

    task automatic run_same(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) step({4{b}}, 1'b0);
    endtask

    initial begin
        #(8 * 190000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        check_regs(0, 0, 0, "R1 reset");

        // R4: samples before the first sync are ignored
        threshold = 0;
        for (int i = 0; i < 40; i++) begin
            rng = next_rng(rng);
            step(rng, 1'b0);
        end
        step(32'h7f7f_7f7f, 1'b1);
        check_regs(0, 0, 0, "R4 first sync");

        // R2 R3 R5 R6 R9: sweep of requested window lengths and thresholds
        for (int wl = 0; wl < 16; wl++) begin
            win_log   = 4'(wl);
            threshold = 32'((1 << clamp_len(wl)) * 5461 + (wl % 3 - 1) * 20000);
            for (int i = 0; i < 37 + wl * 23; i++) begin
                rng = next_rng(rng);
                step(rng, 1'b0);
            end
            rng = next_rng(rng);
            step(rng, 1'b1);
            check_regs(e_pow, e_cnt, e_flag, "R5 sweep");
        end

        // R2: extreme lane values
        threshold = 32'hffff_ffff;
        win_log = 4'd6;
        step(32'h8080_8080, 1'b1);
        run_same(8'h80, 39);
        step(32'h7f7f_7f7f, 1'b1);
        check_regs(40 * 65536, 0, 0, "R2 all -128");
        run_same(8'h7f, 39);
        step(32'h0, 1'b1);
        check_regs(40 * 64516, 0, 0, "R2 all 127");

        // R6: strict compare at equality (window sum 64)
        threshold = 64;
        step(32'h0101_0101, 1'b1);
        run_same(8'h01, 47);
        step(32'h0101_0101, 1'b1);
        check_regs(48 * 4, 0, 0, "R6 equal not counted");
        threshold = 63;
        run_same(8'h01, 47);
        step(32'h0101_0101, 1'b1);
        check_regs(48 * 4, 3, 1, "R6 one above counted");

        // R7: window end coinciding with sync
        threshold = 0;
        run_same(8'h01, 14);
        step(32'h0101_0101, 1'b1);
        check_regs(15 * 4, 0, 0, "R7 sync on last cycle");
        run_same(8'h01, 15);
        step(32'h0101_0101, 1'b1);
        check_regs(16 * 4, 1, 1, "R7 window completes");

        // R5: mid-window change applies to the next window
        win_log = 4'd6;
        step(32'h0101_0101, 1'b1);
        run_same(8'h01, 8);
        win_log = 4'd7;
        run_same(8'h01, 39);
        step(32'h0101_0101, 1'b1);
        check_regs(48 * 4, 2, 1, "R5 change mid window");

        // R8: saturation of the counter
        win_log = 4'd6;
        threshold = 0;
        run_same(8'h01, 1100);
        step(32'h8080_8080, 1'b1);
        check_regs(1101 * 4, CNT_MAX, 1, "R8 saturate");

        // R10 R3: interval power above 32 bits
        threshold = 32'hffff_ffff;
        run_same(8'h80, 69999);
        step(32'h0, 1'b1);
        check_regs(64'd4587520000, 0, 0, "R10 wide power");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule